// File: doc/BRIEF.md
# Transmit Jabber Guard and Collision Heartbeat Generator

This block supervises the transmit-enable line that a MAC drives into a 10 Mb/s twisted-pair transmitter. It has two independent jobs. The first is a jabber guard. When transmit enable stays high without a break for too long, the guard blocks the transmit path and reports the condition. The block is released only after the line has been quiet for a much longer hold-off. The second job is a collision-test heartbeat. A fixed delay after each frame ends, the block raises its collision output for a fixed width, so the MAC can confirm that its collision path works.

All timing is counted in cycles of one clock. At the default 50 MHz clock, one tick is 20 ns. The jabber limit is then 85 ms (4,250,000 ticks) and the release hold-off is 500 ms (25,000,000 ticks). The heartbeat starts 1200 ns (60 ticks) after the frame ends and lasts 1000 ns (50 ticks). Every limit is a parameter, so a bench can shorten the long windows.

Both functions work only while 10 Mb/s mode is selected. In 100 Mb/s mode the block stays idle and lets transmission through. All pins are plain control and status levels; the block has no data stream and no handshake.

Top module: `jabber_hb_supervisor`

## Requirements
- R1: When `tx_en` is sampled high on JAB_TICKS consecutive clock edges, the lockout starts after the last of those edges: `jabber_status` goes to 1 and `tx_allow` goes to 0 in the same cycle.
- R2: A run of JAB_TICKS-1 high samples followed by a low sample does not start a lockout. Any low sample restarts the run count from zero.
- R3: A lockout ends after `tx_en` has been sampled low on REL_TICKS consecutive edges, counted from the edge after the lockout began. `jabber_status` returns to 0 and `tx_allow` returns to 1 in the same cycle.
- R4: A high sample of `tx_en` during the release hold-off restarts the idle count, so the lockout lasts REL_TICKS low samples past that high sample.
- R5: The first edge at which `tx_en` is sampled low after being high marks the end of a frame. `col_heartbeat` rises HB_DELAY cycles after that edge and stays high for exactly HB_WIDTH cycles. The defaults are 60 and 50.
- R6: A frame that ends while the lockout is active produces no heartbeat.
- R7: `col_heartbeat` is 0 whenever `hb_enable` is 0. A frame that ends with `hb_enable` low produces no heartbeat. Lowering `hb_enable` cancels a heartbeat that is pending or in progress, and the heartbeat does not resume when `hb_enable` returns to 1.
- R8: While `mode_10m` is 0, `tx_allow` is 1 and `jabber_status` and `col_heartbeat` are 0, starting in the same cycle. The next edge clears the lockout, both timers and any pending heartbeat. Frames sent in this mode produce neither a lockout nor a heartbeat.
- R9: An asynchronous active-low reset at once sets `tx_allow` to 1 and `jabber_status` and `col_heartbeat` to 0, and clears both timers and the lockout.
- R10: A frame end that occurs while a heartbeat is pending restarts the heartbeat delay from that later frame end.
- R11: Jabber detection and the heartbeat run independently. A lockout declared while the previous frame's heartbeat is high leaves that pulse's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| mode_10m | input | 1 | 1 selects 10 Mb/s operation, 0 selects 100 Mb/s |
| hb_enable | input | 1 | 1 permits the collision-test heartbeat |
| tx_allow | output | 1 | 1 when the transmit path may run |
| jabber_status | output | 1 | 1 while the jabber lockout is in force |
| col_heartbeat | output | 1 | Collision-test pulse after each frame |

## Verification
The jabber declaration and the heartbeat pulse can happen in the same cycle window. To provoke this, a frame ends and a new frame starts five cycles later and then runs long. With the shortened jabber limit, the lockout is then declared while the previous frame's heartbeat is still high. The scoreboard holds the expected edges in cycle order: heartbeat rise, status rise together with allow fall, then heartbeat fall. It judges that the pulse keeps its full width and that the lockout lands on the cycle R1 predicts, with neither function pushing the other off its cycle.

// File: rtl/jhb_pkg.sv
package jhb_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jhb_jabber.sv
module jhb_jabber #(
  parameter int JAB_TICKS = 4250000,
  parameter int REL_TICKS = 25000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_en,
  output logic locked
);
  // One counter serves both phases: a high-run count while armed,
  // an idle count while locked.
  localparam int CW = $clog2(jhb_pkg::max_of(JAB_TICKS, REL_TICKS) + 1);
  localparam logic [CW-1:0] JAB_LAST = CW'(JAB_TICKS - 1);
  localparam logic [CW-1:0] REL_LAST = CW'(REL_TICKS - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      cnt    <= '0;
    end else if (!enable) begin
      locked <= 1'b0;
      cnt    <= '0;
    end else if (!locked) begin
      if (!tx_en) begin
        cnt <= '0;
      end else if (cnt == JAB_LAST) begin
        locked <= 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (tx_en) begin
        cnt <= '0;
      end else if (cnt == REL_LAST) begin
        locked <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  // R1: a lockout can begin only at an edge where transmit enable was high
  a_r1_lock_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tx_en));

  // R3: in 10 Mb/s operation a release only happens on an idle sample
  a_r3_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(enable)) |-> !$past(tx_en));

  // R8: leaving 10 Mb/s mode clears the lockout at the next edge
  a_r8_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !locked);

endmodule

// File: rtl/jhb_heartbeat.sv
module jhb_heartbeat
  import jhb_pkg::*;
#(
  parameter int HB_DELAY = 60,
  parameter int HB_WIDTH = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hb_en,
  input  logic tx_en,
  input  logic block,
  output logic pulse
);
  localparam int CW = $clog2(max_of(HB_DELAY, HB_WIDTH) + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(HB_DELAY);
  localparam logic [CW-1:0] WID_LAST = CW'(HB_WIDTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  hb_state_t     state;
  logic [CW-1:0] cnt;
  logic          tx_q;
  logic          frame_end;

  assign frame_end = tx_q & ~tx_en;
  assign pulse     = (state == HB_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HB_IDLE;
      cnt   <= '0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= tx_en & enable;
      if (!enable || !hb_en) begin
        state <= HB_IDLE;
        cnt   <= '0;
      end else if (frame_end && !block) begin
        state <= HB_WAIT;
        cnt   <= ONE;
      end else begin
        case (state)
          HB_WAIT: begin
            if (cnt == DLY_LAST) begin
              state <= HB_PULSE;
              cnt   <= ONE;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          HB_PULSE: begin
            if (cnt == WID_LAST) begin
              state <= HB_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          default: begin
            state <= HB_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  // Checker counter: length of the current high run of the pulse.
  localparam int LW = $clog2(HB_WIDTH + 2);
  logic [LW-1:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_len <= '0;
    else if (!pulse)     hi_len <= '0;
    else if (hi_len != '1) hi_len <= hi_len + LW'(1);
  end

  // R5: the pulse never stays high for more than its width
  a_r5_width: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= LW'(HB_WIDTH));

  // R5: a pulse only ever follows the delay phase
  a_r5_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(state) == HB_WAIT);

  // R7: clearing the enable leaves nothing pending after the next edge
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_en |=> state == HB_IDLE);

endmodule

// File: rtl/jabber_hb_supervisor.sv
module jabber_hb_supervisor #(
  parameter int JAB_TICKS = 4250000,
  parameter int REL_TICKS = 25000000,
  parameter int HB_DELAY  = 60,
  parameter int HB_WIDTH  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic mode_10m,
  input  logic hb_enable,
  output logic tx_allow,
  output logic jabber_status,
  output logic col_heartbeat
);
  logic locked;
  logic pulse;

  jhb_jabber #(
    .JAB_TICKS(JAB_TICKS),
    .REL_TICKS(REL_TICKS)
  ) u_jabber (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mode_10m),
    .tx_en  (tx_en),
    .locked (locked)
  );

  jhb_heartbeat #(
    .HB_DELAY(HB_DELAY),
    .HB_WIDTH(HB_WIDTH)
  ) u_hb (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mode_10m),
    .hb_en  (hb_enable),
    .tx_en  (tx_en),
    .block  (locked),
    .pulse  (pulse)
  );

  // Outputs are gated at once by the mode and heartbeat enables.
  assign tx_allow      = ~(locked & mode_10m);
  assign jabber_status = locked & mode_10m;
  assign col_heartbeat = pulse & mode_10m & hb_enable;

  // R6: no pulse can begin in the cycle after a blocked frame end
  a_r6_blocked_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_en) && !tx_en && locked) |=> !$rose(pulse));

endmodule

// File: tb/sim_jabber_hb_supervisor.sv
module sim_jabber_hb_supervisor;
  localparam int JAB = 100;
  localparam int REL = 300;
  localparam int DLY = 60;
  localparam int WID = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic mode_10m = 1'b1;
  logic hb_enable = 1'b1;
  logic tx_allow, jabber_status, col_heartbeat;

  always #4 clk = ~clk;  // 125 MHz

  jabber_hb_supervisor #(
    .JAB_TICKS(JAB), .REL_TICKS(REL), .HB_DELAY(DLY), .HB_WIDTH(WID)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_10m(mode_10m),
    .hb_enable(hb_enable), .tx_allow(tx_allow),
    .jabber_status(jabber_status), .col_heartbeat(col_heartbeat)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  // Scoreboard: kind 0 = jabber_status, 1 = tx_allow, 2 = col_heartbeat
  int    q_kind[$];
  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];

  task automatic expect_ev(input int k, input int v, input int c, input string t);
    q_kind.push_back(k); q_val.push_back(v); q_cyc.push_back(c); q_tag.push_back(t);
  endtask

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic drain(input string t);
    chk(q_kind.size() == 0, t, q_kind.size(), 0);
    while (q_kind.size() > 0) begin
      $display("FAIL %s missing event kind=%0d val=%0d at cycle %0d",
               q_tag[0], q_kind[0], q_val[0], q_cyc[0]);
      void'(q_kind.pop_front()); void'(q_val.pop_front());
      void'(q_cyc.pop_front());  void'(q_tag.pop_front());
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor
  bit       mon_on = 1'b0;
  bit [2:0] prev;
  always @(negedge clk) begin
    automatic bit [2:0] cur = {col_heartbeat, tx_allow, jabber_status};
    if (!mon_on) begin
      prev = cur;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (cur[i] != prev[i]) begin
          checks++;
          if (q_kind.size() == 0) begin
            fails++;
            $display("FAIL unexpected event kind=%0d actual=%0d expected=none at cycle %0d",
                     i, cur[i], cyc);
          end else begin
            automatic int    k = q_kind.pop_front();
            automatic int    v = q_val.pop_front();
            automatic int    c = q_cyc.pop_front();
            automatic string t = q_tag.pop_front();
            if (k != i || v != int'(cur[i]) || c != cyc) begin
              fails++;
              $display("FAIL %s actual kind=%0d val=%0d cyc=%0d expected kind=%0d val=%0d cyc=%0d",
                       t, i, cur[i], cyc, k, v, c);
            end
          end
        end
      end
      prev = cur;
    end
  end

  // Watchdog
  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    tick(3);
    chk(tx_allow == 1'b1 && jabber_status == 1'b0 && col_heartbeat == 1'b0,
        "R9 reset state", {tx_allow, jabber_status, col_heartbeat}, 3'b100);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick(2);

    // R5: basic heartbeat after a short frame
    tx_en = 1'b1; tick(20);
    n = cyc; tx_en = 1'b0;
    expect_ev(2, 1, n + DLY + 1, "R5 heartbeat rise");
    expect_ev(2, 0, n + DLY + WID + 1, "R5 heartbeat fall");
    tick(130);
    drain("R5 queue");

    // R2: one sample short of the limit
    tx_en = 1'b1; tick(JAB - 1);
    n = cyc; tx_en = 1'b0;
    expect_ev(2, 1, n + DLY + 1, "R2 heartbeat after near-jabber");
    expect_ev(2, 0, n + DLY + WID + 1, "R2 heartbeat fall");
    tick(130);
    chk(jabber_status == 1'b0, "R2 no lockout", jabber_status, 0);
    drain("R2 queue");

    // R1 / R6 / R4 / R3
    n = cyc; tx_en = 1'b1;
    expect_ev(0, 1, n + JAB, "R1 status rise");
    expect_ev(1, 0, n + JAB, "R1 allow fall");
    tick(150);
    tx_en = 1'b0; tick(100);
    chk(col_heartbeat == 1'b0, "R6 no heartbeat under lockout", col_heartbeat, 0);
    tx_en = 1'b1; tick(1);
    n = cyc; tx_en = 1'b0;
    expect_ev(0, 0, n + REL, "R4/R3 status release");
    expect_ev(1, 1, n + REL, "R4/R3 allow release");
    tick(REL - 5);
    chk(jabber_status == 1'b1, "R4 idle count restarted", jabber_status, 1);
    tick(60);
    chk(tx_allow == 1'b1, "R3 released", tx_allow, 1);
    drain("R1 R3 R4 R6 queue");

    // R7: heartbeat disabled, cancelled, and cut
    hb_enable = 1'b0;
    tx_en = 1'b1; tick(20); tx_en = 1'b0; tick(130);
    chk(col_heartbeat == 1'b0, "R7 disabled frame", col_heartbeat, 0);
    hb_enable = 1'b1;
    tx_en = 1'b1; tick(20); tx_en = 1'b0; tick(30);
    hb_enable = 1'b0; tick(5); hb_enable = 1'b1; tick(120);
    chk(col_heartbeat == 1'b0, "R7 cancelled pending", col_heartbeat, 0);
    tx_en = 1'b1; tick(20);
    n = cyc; tx_en = 1'b0;
    expect_ev(2, 1, n + DLY + 1, "R7 pulse rise");
    tick(70);
    expect_ev(2, 0, cyc, "R7 pulse cut by enable");
    hb_enable = 1'b0; tick(5); hb_enable = 1'b1; tick(80);
    drain("R7 queue");

    // R10: second frame end restarts the delay
    tx_en = 1'b1; tick(20); tx_en = 1'b0; tick(20);
    tx_en = 1'b1; tick(5);
    n = cyc; tx_en = 1'b0;
    expect_ev(2, 1, n + DLY + 1, "R10 restarted rise");
    expect_ev(2, 0, n + DLY + WID + 1, "R10 restarted fall");
    tick(130);
    drain("R10 queue");

    // R8: 100 Mb/s mode
    mode_10m = 1'b0;
    tx_en = 1'b1; tick(JAB + 50); tx_en = 1'b0; tick(130);
    chk(tx_allow == 1'b1 && jabber_status == 1'b0 && col_heartbeat == 1'b0,
        "R8 idle in 100M", {tx_allow, jabber_status, col_heartbeat}, 3'b100);
    mode_10m = 1'b1; tick(2);
    n = cyc; tx_en = 1'b1;
    expect_ev(0, 1, n + JAB, "R8 lock before mode drop");
    expect_ev(1, 0, n + JAB, "R8 allow low before mode drop");
    tick(JAB + 10);
    expect_ev(0, 0, cyc, "R8 status forced low");
    expect_ev(1, 1, cyc, "R8 allow forced high");
    mode_10m = 1'b0; tick(5);
    n = cyc; mode_10m = 1'b1;
    expect_ev(0, 1, n + JAB, "R8 fresh run after mode return");
    expect_ev(1, 0, n + JAB, "R8 fresh allow low");
    tick(JAB + 10);
    expect_ev(0, 0, cyc, "R8 status clear");
    expect_ev(1, 1, cyc, "R8 allow clear");
    mode_10m = 1'b0; tx_en = 1'b0; tick(5);
    mode_10m = 1'b1; tick(130);
    drain("R8 queue");

    // R11: lockout declared during the previous frame's heartbeat
    tx_en = 1'b1; tick(20);
    n = cyc; tx_en = 1'b0;
    tick(5); tx_en = 1'b1;
    expect_ev(2, 1, n + DLY + 1, "R11 pulse rise");
    expect_ev(0, 1, n + 5 + JAB, "R11 status rise in pulse");
    expect_ev(1, 0, n + 5 + JAB, "R11 allow fall in pulse");
    expect_ev(2, 0, n + DLY + WID + 1, "R11 pulse full width");
    tick(JAB + 20);
    n = cyc; tx_en = 1'b0;
    expect_ev(0, 0, n + REL, "R11 release");
    expect_ev(1, 1, n + REL, "R11 allow back");
    tick(REL + 20);
    drain("R11 queue");

    // R9: asynchronous reset during a lockout
    n = cyc; tx_en = 1'b1;
    expect_ev(0, 1, n + JAB, "R9 lock before reset");
    expect_ev(1, 0, n + JAB, "R9 allow low before reset");
    tick(JAB + 10);
    expect_ev(0, 0, cyc, "R9 status cleared by reset");
    expect_ev(1, 1, cyc, "R9 allow set by reset");
    rst_n = 1'b0; tx_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(130);
    chk(col_heartbeat == 1'b0, "R9 no pulse after reset", col_heartbeat, 0);
    drain("R9 queue");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule